// File: doc/BRIEF.md
# Bidirectional Handshaked Bus Port

This block is one 8-bit data port that a CPU and a peripheral share in both directions over a single set of pins. The CPU writes a byte into an output latch. The port then signals buffer-full to the peripheral. When the peripheral pulls its acknowledge pin low, the port drives the latched byte onto the shared pins. At every other time the pins float. In the other direction, the peripheral places a byte on the pins and pulls its strobe low. The port captures the byte into a separate input latch and raises input-buffer-full.

Each direction has a completion condition: output-done and input-ready. Each condition is gated by its own enable bit, and the two gated conditions are ORed onto one interrupt pin. Acknowledge and strobe both low together means two drivers are fighting on the bus. The port does not resolve this silently. It raises a sticky error flag. Three further port-C bits serve as plain general-purpose I/O.

The CPU side is a small synchronous register interface with a 2-bit address, a one-cycle write strobe and a one-cycle read strobe. The pad is modelled as separate out, enable and in signals. All handshake pins are taken as synchronous to `clk`.

Top module: `bhp_port`

## Requirements
- R1: After reset: obfN=1, ibf=0, intr=0, busErr=0, padOe=0, pcOut=0. Both interrupt enables and both latches are 0.
- R2: A write to address 0 loads cpuWrData into the output latch at that edge. From the next cycle, obfN is 0 and output-done is 0.
- R3: padOe equals the inverse of ackN, with no clock delay. padOut always shows the output latch.
- R4: At an edge where ackN is 0 and there is no address-0 write, obfN becomes 1. If both happen at the same edge, the write wins and obfN becomes 0.
- R5: At an edge where stbN=0 and ackN=1, padIn is loaded into the input latch and ibf becomes 1.
- R6: A read at address 0 returns the input latch on cpuRdData in the same cycle. At that edge it clears ibf, unless a load happens at the same edge. It also clears input-ready.
- R7: Output-done becomes 1 at an edge where ackN is 1, ackN was 0 at the previous edge, obfN is 1 and there is no address-0 write. An address-0 write clears it.
- R8: Input-ready becomes 1 at an edge where stbN is 1, stbN was 0 at the previous edge, and ibf is 1. If no such rise occurs, an address-0 read clears it.
- R9: intr = (output-done AND control bit 0) OR (input-ready AND control bit 1).
- R10: When ackN=0 and stbN=0 at an edge, busErr becomes 1 and the input latch and ibf are not loaded. busErr holds until a status read (address 1) at an edge with no conflict.
- R11: A read at address 1 returns status: bit7=NOT obfN, bit6=output-done, bit5=ibf, bit4=input-ready, bit3=intr, bit2=busErr, bits1:0=0.
- R12: Address 2 is the control register. A write sets bit0 (output interrupt enable), bit1 (input interrupt enable) and bits4:2 into pcOut. A read returns {pcIn, pcOut, bit1, bit0}. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 2 | Register select: 0 data, 1 status, 2 control |
| cpuWr | input | 1 | One-cycle CPU write strobe |
| cpuRd | input | 1 | One-cycle CPU read strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data, combinational from cpuAddr |
| padIn | input | 8 | Value seen on the shared data pins |
| padOut | output | 8 | Value driven on the shared data pins |
| padOe | output | 1 | Pin driver enable |
| obfN | output | 1 | Output buffer full, active low (PC7) |
| ackN | input | 1 | Peripheral acknowledge, active low (PC6) |
| ibf | output | 1 | Input buffer full (PC5) |
| stbN | input | 1 | Peripheral strobe, active low (PC4) |
| intr | output | 1 | Shared interrupt (PC3) |
| pcIn | input | 3 | General-purpose inputs (PC2..PC0) |
| pcOut | output | 3 | General-purpose outputs (PC2..PC0) |
| busErr | output | 1 | Sticky bus conflict flag |

## Verification
The bench targets the collisions between the two handshakes and the CPU:
- **CPU write during acknowledge.** A design that gave acknowledge priority would report an empty buffer while new data is still unsent.
- **Strobe and acknowledge together.** A design that loaded anyway would capture its own driven byte as input and miss the error flag.
- **Read coinciding with a strobe load.** A design that let the read win would lose the buffer-full indication for a byte that was just captured.
- **Write at the moment acknowledge rises.** A design that let the set win would keep output-done up over freshly written data.

Long random runs drive overlapping ack and strobe pulses to reach these interactions, and a cycle-level model predicts every output.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  // strobes from the control to the datapath
  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic rdData;
    logic loadIn;
  } bhpStrobes_t;
endpackage

// File: rtl/bhp_ctrl.sv
module bhp_ctrl
  import bhp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic              ackN,
  input  logic              stbN,
  input  logic              outIntEn,
  input  logic              inIntEn,
  output bhpStrobes_t       strobes,
  output logic              obfN,
  output logic              ibf,
  output logic              outDone,
  output logic              inReady,
  output logic              intr,
  output logic              busErr
);
  logic ackPrev, stbPrev;
  logic wrData, rdData, rdStat, wrCtrl;
  logic conflict, loadIn, ackRise, stbRise;

  assign wrData   = cpuWr && (cpuAddr == ADDR_DATA);
  assign wrCtrl   = cpuWr && (cpuAddr == ADDR_CTRL);
  assign rdData   = cpuRd && (cpuAddr == ADDR_DATA);
  assign rdStat   = cpuRd && (cpuAddr == ADDR_STAT);
  assign conflict = !ackN && !stbN;
  assign loadIn   = !stbN && ackN;
  assign ackRise  = ackN && !ackPrev;
  assign stbRise  = stbN && !stbPrev;

  always_comb begin
    strobes.wrData = wrData;
    strobes.wrCtrl = wrCtrl;
    strobes.rdData = rdData;
    strobes.loadIn = loadIn;
  end

  assign intr = (outDone && outIntEn) || (inReady && inIntEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackPrev <= 1'b1;
      stbPrev <= 1'b1;
      obfN    <= 1'b1;
      ibf     <= 1'b0;
      outDone <= 1'b0;
      inReady <= 1'b0;
      busErr  <= 1'b0;
    end else begin
      ackPrev <= ackN;
      stbPrev <= stbN;
      // output side: write wins over acknowledge
      if (wrData)     obfN <= 1'b0;
      else if (!ackN) obfN <= 1'b1;
      if (wrData)                outDone <= 1'b0;
      else if (ackRise && obfN)  outDone <= 1'b1;
      // input side: load wins over read
      if (loadIn)      ibf <= 1'b1;
      else if (rdData) ibf <= 1'b0;
      if (stbRise && ibf) inReady <= 1'b1;
      else if (rdData)    inReady <= 1'b0;
      // bus fight
      if (conflict)    busErr <= 1'b1;
      else if (rdStat) busErr <= 1'b0;
    end
  end

  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrData |=> !obfN); // R2
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && !wrData) |=> obfN); // R4
  AST_IBF_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    loadIn |=> ibf); // R5
  AST_CONFLICT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    conflict |=> busErr); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && !rdStat) |=> busErr); // R10
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    wrData |=> !outDone); // R7
endmodule

// File: rtl/bhp_dp.sv
module bhp_dp
  import bhp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GPIO_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bhpStrobes_t       strobes,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] padIn,
  input  logic [GPIO_W-1:0] pcIn,
  input  logic              obfN,
  input  logic              ibf,
  input  logic              outDone,
  input  logic              inReady,
  input  logic              intr,
  input  logic              busErr,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] padOut,
  output logic [GPIO_W-1:0] pcOut,
  output logic              outIntEn,
  output logic              inIntEn
);
  localparam int CTRL_W = 2 + 2 * GPIO_W;
  localparam int STAT_W = 6;

  logic [DATA_W-1:0] outLatch, inLatch;
  logic [DATA_W-1:0] statWord, ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= '0;
      inLatch  <= '0;
      pcOut    <= '0;
      outIntEn <= 1'b0;
      inIntEn  <= 1'b0;
    end else begin
      if (strobes.wrData) outLatch <= cpuWrData;
      if (strobes.loadIn) inLatch  <= padIn;
      if (strobes.wrCtrl) begin
        outIntEn <= cpuWrData[0];
        inIntEn  <= cpuWrData[1];
        pcOut    <= cpuWrData[2 +: GPIO_W];
      end
    end
  end

  always_comb begin
    statWord = '0;
    statWord[DATA_W-1 -: STAT_W] = {!obfN, outDone, ibf, inReady, intr, busErr};
    ctrlWord = '0;
    ctrlWord[CTRL_W-1:0] = {pcIn, pcOut, inIntEn, outIntEn};
    unique case (cpuAddr)
      ADDR_DATA: cpuRdData = inLatch;
      ADDR_STAT: cpuRdData = statWord;
      ADDR_CTRL: cpuRdData = ctrlWord;
      default:   cpuRdData = '0;
    endcase
  end

  assign padOut = outLatch;

  AST_WRITE_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrData |=> (padOut == $past(cpuWrData))); // R2
  AST_INPUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadIn |=> $stable(inLatch)); // R10
  AST_INPUT_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIn |=> (inLatch == $past(padIn))); // R5
endmodule

// File: rtl/bhp_port.sv
module bhp_port
  import bhp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GPIO_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic              padOe,
  output logic              obfN,
  input  logic              ackN,
  output logic              ibf,
  input  logic              stbN,
  output logic              intr,
  input  logic [GPIO_W-1:0] pcIn,
  output logic [GPIO_W-1:0] pcOut,
  output logic              busErr
);
  bhpStrobes_t strobes;
  logic outDone, inReady, outIntEn, inIntEn;

  // pins driven only while the peripheral acknowledges
  assign padOe = !ackN;

  bhp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .ackN(ackN), .stbN(stbN), .outIntEn(outIntEn), .inIntEn(inIntEn),
    .strobes(strobes), .obfN(obfN), .ibf(ibf), .outDone(outDone),
    .inReady(inReady), .intr(intr), .busErr(busErr)
  );

  bhp_dp #(.DATA_W(DATA_W), .GPIO_W(GPIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .padIn(padIn), .pcIn(pcIn), .obfN(obfN),
    .ibf(ibf), .outDone(outDone), .inReady(inReady), .intr(intr),
    .busErr(busErr), .cpuRdData(cpuRdData), .padOut(padOut), .pcOut(pcOut),
    .outIntEn(outIntEn), .inIntEn(inIntEn)
  );
endmodule

// File: tb/bhp_port_tb.sv
`timescale 1ns/1ps
module bhp_port_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic cpuWr = 1'b0, cpuRd = 1'b0;
  logic [7:0] cpuWrData = '0, padIn = '0;
  logic [7:0] cpuRdData, padOut;
  logic padOe, obfN, ibf, intr, busErr;
  logic ackN = 1'b1, stbN = 1'b1;
  logic [2:0] pcIn = '0, pcOut;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // reference state
  logic [7:0] mOut, mIn;
  logic mObfN, mIbf, mOutDone, mInRdy, mErr, mEnO, mEnI, mAckPrev, mStbPrev;
  logic [2:0] mPc;

  always #4 clk = ~clk;

  bhp_port u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .obfN(obfN), .ackN(ackN), .ibf(ibf),
    .stbN(stbN), .intr(intr), .pcIn(pcIn), .pcOut(pcOut), .busErr(busErr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic expIntr();
    return (mOutDone && mEnO) || (mInRdy && mEnI);
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mIn;
      2'd1: return {!mObfN, mOutDone, mIbf, mInRdy, expIntr(), mErr, 2'b00};
      2'd2: return {pcIn, mPc, mEnI, mEnO};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelReset();
    mOut = 0; mIn = 0; mObfN = 1; mIbf = 0; mOutDone = 0; mInRdy = 0;
    mErr = 0; mEnO = 0; mEnI = 0; mPc = 0; mAckPrev = 1; mStbPrev = 1;
  endtask

  task automatic modelStep();
    logic wd, rd, rs, wc, ld, cf;
    wd = cpuWr && cpuAddr == 0; wc = cpuWr && cpuAddr == 2;
    rd = cpuRd && cpuAddr == 0; rs = cpuRd && cpuAddr == 1;
    cf = !ackN && !stbN; ld = !stbN && ackN;
    if (wd) mOutDone = 0; else if (ackN && !mAckPrev && mObfN) mOutDone = 1;
    if (stbN && !mStbPrev && mIbf) mInRdy = 1; else if (rd) mInRdy = 0;
    if (wd) mObfN = 0; else if (!ackN) mObfN = 1;
    if (ld) mIbf = 1; else if (rd) mIbf = 0;
    if (cf) mErr = 1; else if (rs) mErr = 0;
    if (wd) mOut = cpuWrData;
    if (ld) mIn = padIn;
    if (wc) begin mEnO = cpuWrData[0]; mEnI = cpuWrData[1]; mPc = cpuWrData[4:2]; end
    mAckPrev = ackN; mStbPrev = stbN;
  endtask

  // drive at negedge, compare, advance model for the coming edge
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [7:0] wdat, input logic ak, input logic sb,
                     input logic [7:0] pin);
    @(negedge clk);
    cpuWr = wr; cpuRd = rd; cpuAddr = a; cpuWrData = wdat;
    ackN = ak; stbN = sb; padIn = pin; pcIn = 3'($urandom);
    #1;
    chk("R3 padOe", {7'd0, padOe}, {7'd0, !ak});
    chk("R3 padOut", padOut, mOut);
    chk("R2 R4 obfN", {7'd0, obfN}, {7'd0, mObfN});
    chk("R5 R6 ibf", {7'd0, ibf}, {7'd0, mIbf});
    chk("R9 intr", {7'd0, intr}, {7'd0, expIntr()});
    chk("R10 busErr", {7'd0, busErr}, {7'd0, mErr});
    chk("R12 pcOut", {5'd0, pcOut}, {5'd0, mPc});
    chk("R6 R11 R12 cpuRdData", cpuRdData, expRead(a));
    modelStep();
  endtask

  task automatic idle(); cyc(0, 0, 2'd3, 8'h00, 1, 1, 8'h00); endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    #1;
    chk("R1 obfN", {7'd0, obfN}, 8'd1);
    chk("R1 ibf", {7'd0, ibf}, 8'd0);
    chk("R1 intr", {7'd0, intr}, 8'd0);
    chk("R1 busErr", {7'd0, busErr}, 8'd0);
    chk("R1 padOe", {7'd0, padOe}, 8'd0);
    chk("R1 pcOut", {5'd0, pcOut}, 8'd0);
    chk("R1 padOut", padOut, 8'd0);

    // enable both interrupts, pcOut = 3'b101
    cyc(1, 0, 2'd2, 8'b0001_0111, 1, 1, 0);
    // R2: write, then R4: ack pulse, R7: ack rise sets done
    cyc(1, 0, 2'd0, 8'hA5, 1, 1, 0);
    idle();
    cyc(0, 0, 2'd3, 0, 0, 1, 0);
    cyc(0, 0, 2'd3, 0, 0, 1, 0);
    cyc(0, 1, 2'd1, 0, 1, 1, 0);
    cyc(0, 1, 2'd1, 0, 1, 1, 0);
    chk("R7 outDone set", cpuRdData & 8'h40, 8'h40);
    chk("R9 intr from output", {7'd0, intr}, 8'd1);
    // write during ack: write wins (R4)
    cyc(1, 0, 2'd0, 8'h3C, 0, 1, 0);
    idle();
    chk("R4 write wins obfN", {7'd0, obfN}, 8'd0);
    chk("R7 done cleared", {7'd0, intr}, 8'd0);
    // strobe in (R5), rise sets ready (R8), read clears (R6)
    cyc(0, 0, 2'd3, 0, 1, 0, 8'h5A);
    cyc(0, 0, 2'd3, 0, 1, 1, 8'h00);
    cyc(0, 1, 2'd1, 0, 1, 1, 0);
    chk("R8 inReady set", cpuRdData & 8'h10, 8'h10);
    cyc(0, 1, 2'd0, 0, 1, 1, 0);
    chk("R6 read data", cpuRdData, 8'h5A);
    idle();
    chk("R6 ibf cleared", {7'd0, ibf}, 8'd0);
    // read together with a load: ibf stays (R6)
    cyc(0, 1, 2'd0, 0, 1, 0, 8'h77);
    idle();
    chk("R6 load beats read", {7'd0, ibf}, 8'd1);
    // conflict: no load, error flagged (R10)
    cyc(0, 0, 2'd3, 0, 0, 0, 8'hEE);
    idle();
    chk("R10 busErr", {7'd0, busErr}, 8'd1);
    cyc(0, 1, 2'd0, 0, 1, 1, 0);
    chk("R10 no load on conflict", cpuRdData, 8'h77);
    cyc(0, 1, 2'd1, 0, 1, 1, 0);
    idle();
    chk("R10 cleared by status read", {7'd0, busErr}, 8'd0);
    // write exactly when ack rises: write wins (R7)
    cyc(1, 0, 2'd0, 8'h11, 1, 1, 0);
    cyc(0, 0, 2'd3, 0, 0, 1, 0);
    cyc(1, 0, 2'd0, 8'h22, 1, 1, 0);
    cyc(0, 1, 2'd1, 0, 1, 1, 0);
    chk("R7 write beats set", cpuRdData & 8'h40, 8'h00);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      a = 2'($urandom);
      cyc(($urandom % 4) == 0, ($urandom % 3) == 0, a, 8'($urandom),
          ($urandom % 10) >= 3, ($urandom % 10) >= 3, 8'($urandom));
    end
    idle();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule